// File: doc/BRIEF.md
# Spill Source Period Validator and Selector

This block tracks two external spill-start sources: an asynchronous TTL level input and a single-cycle spill strobe from the timing network. For each source it counts millisecond ticks between successive events, keeps the last measured interval, and flags the source as healthy when that interval lies inside a programmable window. A healthy flag is dropped when a source goes quiet for longer than the window's upper bound.

A registered two-bit selection code tells the downstream phase sequencer which source should start spills. The code is either forced by a mode input or, in automatic mode, picked by fixed priority from the health flags. It may only change while the sequencer reports that it is between spills. The millisecond timebase comes in as a one-cycle tick from a chip-wide prescaler, so the block itself holds no clock divider. Software normally programs the window as 1000 ms to 30000 ms.

Top module: `spill_src_sel`

## Requirements
- R1: The TTL input passes through a two-stage synchronizer and a rising-edge detector. A low-to-high transition is one event, however long the level then stays high, and a falling edge is no event.
- R2: On an event, the period output of that source takes the number of `ms_tick` pulses seen after the previous event, up to and including the event's own cycle. The internal count saturates at its all-ones value. The first event after `rst` or `soft_rst` only arms the source and leaves the period unchanged.
- R3: On an event that records a period, the OK flag of that source becomes 1 when `min_period <= period <= max_period` (both bounds inclusive) and 0 otherwise.
- R4: An armed source whose tick count since its last event exceeds `max_period` has its OK flag cleared at once, without waiting for the next event.
- R5: `soft_rst` clears both periods, both OK flags and the armed state, and leaves `sel_src` unchanged.
- R6: `mode` codes are 0 off, 1 soft, 2 TTL, 3 network and 4 automatic; codes 5 to 7 act as off. `sel_src` codes are 0 off, 1 soft, 2 TTL and 3 network. A forced mode selects its source whatever the OK flags are.
- R7: In automatic mode the selection is network if `net_ok` is 1, else TTL if `ttl_ok` is 1, else soft.
- R8: `sel_src` is loaded only at a clock edge where `spill_idle` is 1, from the mode and flags present in that cycle. At every other edge it holds its value.
- R9: After `rst`, both periods, both OK flags and `sel_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Clears measurements and health flags |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ttl_in | input | 1 | Asynchronous TTL spill-start level |
| net_strobe | input | 1 | Synchronous one-cycle network spill strobe |
| spill_idle | input | 1 | High while between spills; selection may change |
| mode | input | 3 | Source mode: 0 off, 1 soft, 2 TTL, 3 network, 4 auto |
| min_period | input | PW | Lower bound of the accepted period, ms |
| max_period | input | PW | Upper bound of the accepted period, ms |
| ttl_ok | output | 1 | TTL source healthy |
| net_ok | output | 1 | Network source healthy |
| ttl_period | output | PW | Last measured TTL period, ms |
| net_period | output | PW | Last measured network period, ms |
| sel_src | output | 2 | Selected source: 0 off, 1 soft, 2 TTL, 3 network |

## Verification
The assertions check on every cycle that a health flag rises only on an event and only with a period inside the window sampled at that event. They also check that a period changes only after an event or a soft reset, that soft reset empties all measurement state, that the selection moves only after an idle cycle, and that the network source wins in automatic mode. Only the bench scenarios can show that the measured values are correct tick counts, that the window bounds are inclusive over a sweep of bounds and intervals, and that a silent source times out exactly one tick past the maximum. The same holds for the TTL level filtering and for the full mode decoding.

// File: rtl/spill_sel_pkg.sv
package spill_sel_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SOFT = 2'd1,
    SRC_TTL  = 2'd2,
    SRC_NET  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_SOFT = 3'd1,
    MODE_TTL  = 3'd2,
    MODE_NET  = 3'd3,
    MODE_AUTO = 3'd4
  } mode_e;

  localparam int NUM_SRC = 2;
  localparam int IDX_TTL = 0;
  localparam int IDX_NET = 1;

endpackage

// File: rtl/spill_edge_sync.sv
module spill_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/spill_period_meter.sv
module spill_period_meter #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          tick_i,
  input  logic          event_i,
  input  logic [PW-1:0] min_i,
  input  logic [PW-1:0] max_i,
  output logic [PW-1:0] period_o,
  output logic          ok_o
);

  localparam logic [PW-1:0] CNT_SAT = '1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] period_q;
  logic          armed_q;
  logic          ok_q;
  logic [PW-1:0] elapsed;
  logic          in_window;
  logic          overrun;

  // ticks since last event, counting one in this cycle, saturating
  always_comb begin
    if (tick_i && (cnt_q != CNT_SAT)) elapsed = cnt_q + 1'b1;
    else                              elapsed = cnt_q;
    in_window = (elapsed >= min_i) && (elapsed <= max_i);
    overrun   = elapsed > max_i;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cnt_q    <= '0;
      period_q <= '0;
      armed_q  <= 1'b0;
      ok_q     <= 1'b0;
    end else if (event_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) begin
        period_q <= elapsed;
        ok_q     <= in_window;
      end
    end else begin
      cnt_q <= elapsed;
      if (armed_q && overrun) ok_q <= 1'b0;
    end
  end

  assign period_o = period_q;
  assign ok_o     = ok_q;

endmodule

// File: rtl/spill_src_arbiter.sv
module spill_src_arbiter
  import spill_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_i,
  input  logic [2:0]         mode_i,
  input  logic [NUM_SRC-1:0] ok_i,
  output logic [1:0]         sel_o
);

  src_e sel_q;
  src_e sel_d;

  always_comb begin
    case (mode_i)
      MODE_SOFT: sel_d = SRC_SOFT;
      MODE_TTL:  sel_d = SRC_TTL;
      MODE_NET:  sel_d = SRC_NET;
      MODE_AUTO: begin
        if (ok_i[IDX_NET])      sel_d = SRC_NET;
        else if (ok_i[IDX_TTL]) sel_d = SRC_TTL;
        else                    sel_d = SRC_SOFT;
      end
      default:   sel_d = SRC_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= SRC_OFF;
    else if (idle_i) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/spill_src_sel.sv
module spill_src_sel
  import spill_sel_pkg::*;
#(
  parameter int PW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          ms_tick,
  input  logic          ttl_in,
  input  logic          net_strobe,
  input  logic          spill_idle,
  input  logic [2:0]    mode,
  input  logic [PW-1:0] min_period,
  input  logic [PW-1:0] max_period,
  output logic          ttl_ok,
  output logic          net_ok,
  output logic [PW-1:0] ttl_period,
  output logic [PW-1:0] net_period,
  output logic [1:0]    sel_src
);

  logic               ttl_rise;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] ok_vec;
  logic [PW-1:0]      per_arr [NUM_SRC];

  spill_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ttl_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (ttl_in),
    .rise_o (ttl_rise)
  );

  assign evt[IDX_TTL] = ttl_rise;
  assign evt[IDX_NET] = net_strobe;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_meter
    spill_period_meter #(.PW(PW)) u_meter (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst),
      .tick_i   (ms_tick),
      .event_i  (evt[s]),
      .min_i    (min_period),
      .max_i    (max_period),
      .period_o (per_arr[s]),
      .ok_o     (ok_vec[s])
    );
  end

  spill_src_arbiter u_arb (
    .clk    (clk),
    .rst    (rst),
    .idle_i (spill_idle),
    .mode_i (mode),
    .ok_i   (ok_vec),
    .sel_o  (sel_src)
  );

  assign ttl_ok     = ok_vec[IDX_TTL];
  assign net_ok     = ok_vec[IDX_NET];
  assign ttl_period = per_arr[IDX_TTL];
  assign net_period = per_arr[IDX_NET];

endmodule

// File: rtl/spill_src_sel_chk.sv
module spill_src_sel_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic          net_strobe,
  input logic          spill_idle,
  input logic [2:0]    mode,
  input logic [PW-1:0] min_period,
  input logic [PW-1:0] max_period,
  input logic          ttl_ok,
  input logic          net_ok,
  input logic [PW-1:0] ttl_period,
  input logic [PW-1:0] net_period,
  input logic [1:0]    sel_src
);

  assert_net_ok_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(net_ok) |-> (net_period >= $past(min_period)) && (net_period <= $past(max_period)));

  assert_ttl_ok_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ttl_ok) |-> (ttl_period >= $past(min_period)) && (ttl_period <= $past(max_period)));

  assert_net_ok_on_event_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(net_ok) |-> $past(net_strobe));

  assert_net_period_update_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(net_period) |-> ($past(net_strobe) || $past(soft_rst)));

  assert_soft_clear_R5: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!ttl_ok && !net_ok && ttl_period == '0 && net_period == '0));

  assert_sel_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_src) |-> $past(spill_idle));

  assert_auto_net_first_R7: assert property (@(posedge clk) disable iff (rst)
    (spill_idle && mode == 3'd4 && net_ok) |=> (sel_src == 2'd3));

endmodule

bind spill_src_sel spill_src_sel_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .net_strobe (net_strobe),
  .spill_idle (spill_idle),
  .mode       (mode),
  .min_period (min_period),
  .max_period (max_period),
  .ttl_ok     (ttl_ok),
  .net_ok     (net_ok),
  .ttl_period (ttl_period),
  .net_period (net_period),
  .sel_src    (sel_src)
);

// File: tb/spill_src_sel_tb.sv
module spill_src_sel_tb;

  localparam int PW     = 16;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic          ms_tick = 1'b0;
  logic          ttl_in = 1'b0;
  logic          net_strobe = 1'b0;
  logic          spill_idle = 1'b0;
  logic [2:0]    mode = 3'd4;
  logic [PW-1:0] min_period = 16'd3;
  logic [PW-1:0] max_period = 16'd8;
  logic          ttl_ok, net_ok;
  logic [PW-1:0] ttl_period, net_period;
  logic [1:0]    sel_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  spill_src_sel #(.PW(PW)) u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ms_tick(ms_tick),
    .ttl_in(ttl_in), .net_strobe(net_strobe), .spill_idle(spill_idle),
    .mode(mode), .min_period(min_period), .max_period(max_period),
    .ttl_ok(ttl_ok), .net_ok(net_ok), .ttl_period(ttl_period),
    .net_period(net_period), .sel_src(sel_src)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ms_tick = 1'b1; cyc(1);
      ms_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic net_pulse();
    net_strobe = 1'b1; cyc(1);
    net_strobe = 1'b0; cyc(1);
  endtask

  task automatic ttl_pulse();
    ttl_in = 1'b1; cyc(6);
    ttl_in = 1'b0; cyc(6);
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", guard, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    chk("R9 ttl_period", int'(ttl_period), 0);
    chk("R9 net_period", int'(net_period), 0);
    chk("R9 ttl_ok", int'(ttl_ok), 0);
    chk("R9 net_ok", int'(net_ok), 0);
    chk("R9 sel_src", int'(sel_src), 0);

    // R2 first event only arms
    ticks(5);
    net_pulse();
    chk("R2 first net event period", int'(net_period), 0);
    chk("R2 first net event ok", int'(net_ok), 0);

    // R2/R3 sweep of window bounds and intervals
    for (int lo = 2; lo <= 4; lo++) begin
      for (int hi = 5; hi <= 7; hi++) begin
        for (int n = 1; n <= 8; n++) begin
          min_period = PW'(lo);
          max_period = PW'(hi);
          ticks(n);
          net_pulse();
          chk("R2 net period", int'(net_period), n);
          chk("R3 net ok", int'(net_ok), int'(n >= lo && n <= hi));
        end
      end
    end

    // R4 timeout one tick past max
    min_period = 16'd3;
    max_period = 16'd8;
    ticks(5);
    net_pulse();
    chk("R3 net ok before timeout", int'(net_ok), 1);
    ticks(8);
    chk("R4 net ok at max", int'(net_ok), 1);
    ticks(1);
    chk("R4 net ok after max", int'(net_ok), 0);

    // R1 TTL path
    ttl_pulse();
    chk("R1 first ttl event period", int'(ttl_period), 0);
    for (int n = 2; n <= 9; n++) begin
      ticks(n);
      ttl_pulse();
      chk("R1 ttl period", int'(ttl_period), n);
      chk("R3 ttl ok", int'(ttl_ok), int'(n >= 3 && n <= 8));
    end
    // R1 level held high is one event, fall is none
    ttl_in = 1'b1; cyc(4);
    ticks(4);
    ttl_in = 1'b0;
    ticks(2);
    cyc(4);
    ttl_pulse();
    chk("R1 held level period", int'(ttl_period), 6);
    chk("R1 held level ok", int'(ttl_ok), 1);

    // R7 auto priority
    spill_idle = 1'b1; cyc(2);
    spill_idle = 1'b0;
    chk("R7 auto ttl only", int'(sel_src), 2);
    net_pulse();
    ticks(4);
    net_pulse();
    chk("R3 net ok again", int'(net_ok), 1);
    cyc(2);
    chk("R8 hold while busy", int'(sel_src), 2);
    spill_idle = 1'b1; cyc(2);
    spill_idle = 1'b0;
    chk("R7 auto net first", int'(sel_src), 3);

    // R5 soft reset
    soft_rst = 1'b1; cyc(1);
    soft_rst = 1'b0;
    chk("R5 ttl_period", int'(ttl_period), 0);
    chk("R5 net_period", int'(net_period), 0);
    chk("R5 ttl_ok", int'(ttl_ok), 0);
    chk("R5 net_ok", int'(net_ok), 0);
    chk("R5 sel kept", int'(sel_src), 3);
    spill_idle = 1'b1; cyc(2);
    spill_idle = 1'b0;
    chk("R7 auto none ok", int'(sel_src), 1);
    ticks(3);
    net_pulse();
    chk("R5 disarmed first event", int'(net_period), 0);

    // R6 forced modes
    spill_idle = 1'b1;
    for (int m = 0; m <= 7; m++) begin
      mode = 3'(m);
      cyc(2);
      chk("R6 forced mode", int'(sel_src), (m <= 3) ? m : ((m == 4) ? 1 : 0));
    end
    // R8 change applied only with idle
    mode = 3'd2; cyc(2);
    spill_idle = 1'b0;
    mode = 3'd3; cyc(3);
    chk("R8 no change when busy", int'(sel_src), 2);
    spill_idle = 1'b1; cyc(1);
    chk("R8 change after idle", int'(sel_src), 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule